// File: doc/BRIEF.md
# Iterative AES-128 Encryption Engine

This block encrypts one 128-bit block with AES-128, finishing one cipher round per clock. A small controller walks through named states. RESET is entered while `rst` is high. WAIT idles until a load request arrives. R0 applies the initial round-key addition. R1 to R9 each apply a full round. R10 applies the final round, which has no column mixing.

The round keys come from a companion key expander that runs in parallel with the engine. The engine holds no key storage. During each round state it XORs in whatever 128-bit key is present on `rkey_in`. After R10 the controller returns to WAIT with `done` high. The ciphertext stays on `cipher_out` until the next load.

The named transitions are:
- RESET→WAIT, taken unconditionally once reset is released.
- WAIT→WAIT while `load` is low.
- WAIT→R0 on `load`.
- Rn→Rn+1 for n from 0 to 9.
- R10→WAIT.

Top module: `aes128_iter_enc`

## Requirements
- R1: While `rst` is high (synchronous, active high) and afterwards without a load, `done` is 0 and `cipher_out` is 0. A reset in the middle of a run abandons it, and the run does not resume.
- R2: Byte k of a 128-bit word sits in bits [127-8k -: 8]. It maps to state row k mod 4, column k div 4. The same mapping holds for the plaintext, the round keys and the ciphertext.
- R3: With the round keys supplied on schedule, `cipher_out` equals the standard AES-128 encryption of the loaded plaintext. The bench checks three known-answer pairs.
- R4: A `load` sampled high in WAIT at clock edge E starts a run. `done` rises at edge E+11 and not before.
- R5: While `done` is 0, `cipher_out` is all zeros.
- R6: While in WAIT with `done` high and `load` low, `done` and `cipher_out` stay constant.
- R7: A `load` accepted while a result is shown restarts the engine at R0 and clears `done` at the very next edge.
- R8: A `load` raised during R0 to R10 is ignored. The run continues one state per clock with an unchanged result.
- R9: Key timing: `rkey_in` must carry round key i between edges E+i and E+i+1, for i from 0 to 10. `rkey_in` and `plain_in` are ignored in WAIT.
- R10: R0 performs only the key XOR. R1 to R9 perform byte substitution, row rotation (row r left by r bytes), column mixing and the key XOR. R10 omits the column mixing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start request, sampled in WAIT |
| plain_in | input | 128 | Plaintext block, captured on an accepted load |
| rkey_in | input | 128 | Round key for the current round state |
| cipher_out | output | 128 | Ciphertext while `done` is high, zero otherwise |
| done | output | 1 | Result valid flag |

## Verification
The embedded properties assume that `load` is a clean level sampled on the rising edge. They also assume that the key expander presents round key i exactly during the i-th cycle after the accepting edge. The properties themselves follow only the controller sequence and the result-hold behaviour.

The bench acts as the key expander. It derives the round keys with its own expansion routine and changes `rkey_in`, `plain_in` and `load` only at falling edges. It counts the cycles from the accepting edge so that every key lands in its slot. Outside the slots it places unrelated patterns on the inputs, so that any dependence on them shows up.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

    localparam int BYTE_W      = 8;
    localparam int ROWS        = 4;
    localparam int COLS        = 4;
    localparam int BLOCK_BYTES = ROWS * COLS;
    localparam int BLOCK_W     = BYTE_W * BLOCK_BYTES;
    localparam int ROUNDS      = 10;
    localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;

    typedef enum logic [3:0] {
        ST_RESET, ST_WAIT,
        ST_R0, ST_R1, ST_R2, ST_R3, ST_R4, ST_R5,
        ST_R6, ST_R7, ST_R8, ST_R9, ST_R10
    } ctl_state_t;

    typedef enum logic [1:0] {
        OP_KEY_ONLY,
        OP_FULL,
        OP_LAST
    } round_op_t;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic logic [BYTE_W-1:0] xtime(input logic [BYTE_W-1:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_eng_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    output logic [BYTE_W-1:0] s_o
);

    logic [BYTE_W-1:0] p3, p7, p15, p31, p63, p127, inv;

    // a^254 is the field inverse (and maps 0 to 0)
    always_comb begin
        p3   = gf_mul(gf_mul(a_i, a_i), a_i);
        p7   = gf_mul(gf_mul(p3, p3), a_i);
        p15  = gf_mul(gf_mul(p7, p7), a_i);
        p31  = gf_mul(gf_mul(p15, p15), a_i);
        p63  = gf_mul(gf_mul(p31, p31), a_i);
        p127 = gf_mul(gf_mul(p63, p63), a_i);
        inv  = gf_mul(p127, p127);
        s_o  = inv
             ^ {inv[6:0], inv[7]}
             ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]}
             ^ {inv[3:0], inv[7:4]}
             ^ AFFINE_C;
    end

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
    import aes_eng_pkg::*;
(
    input  logic [BLOCK_W-1:0] blk_i,
    input  logic [BLOCK_W-1:0] rkey_i,
    input  round_op_t          op_i,
    output logic [BLOCK_W-1:0] blk_o
);

    logic [BYTE_W-1:0] in_b [BLOCK_BYTES];
    logic [BYTE_W-1:0] sub_b[BLOCK_BYTES];
    logic [BYTE_W-1:0] rot_b[BLOCK_BYTES];
    logic [BYTE_W-1:0] mix_b[BLOCK_BYTES];
    logic [BLOCK_W-1:0] rot_flat;
    logic [BLOCK_W-1:0] mix_flat;
    logic [BLOCK_W-1:0] pre_key;

    genvar g;
    generate
        for (g = 0; g < BLOCK_BYTES; g++) begin : g_byte
            localparam int ROW = g % ROWS;
            localparam int COL = g / ROWS;
            localparam int SRC = ROWS * ((COL + ROW) % COLS) + ROW;

            assign in_b[g] = blk_i[BLOCK_W-1-BYTE_W*g -: BYTE_W];

            aes_sbox u_sb (
                .a_i (in_b[g]),
                .s_o (sub_b[g])
            );

            // row ROW rotated left by ROW positions
            assign rot_b[g] = sub_b[SRC];

            assign rot_flat[BLOCK_W-1-BYTE_W*g -: BYTE_W] = rot_b[g];
            assign mix_flat[BLOCK_W-1-BYTE_W*g -: BYTE_W] = mix_b[g];
        end

        for (g = 0; g < COLS; g++) begin : g_col
            localparam int B = ROWS * g;
            logic [BYTE_W-1:0] d0, d1, d2, d3;
            assign d0 = xtime(rot_b[B]);
            assign d1 = xtime(rot_b[B+1]);
            assign d2 = xtime(rot_b[B+2]);
            assign d3 = xtime(rot_b[B+3]);
            assign mix_b[B]   = d0 ^ (d1 ^ rot_b[B+1]) ^ rot_b[B+2] ^ rot_b[B+3];
            assign mix_b[B+1] = rot_b[B] ^ d1 ^ (d2 ^ rot_b[B+2]) ^ rot_b[B+3];
            assign mix_b[B+2] = rot_b[B] ^ rot_b[B+1] ^ d2 ^ (d3 ^ rot_b[B+3]);
            assign mix_b[B+3] = (d0 ^ rot_b[B]) ^ rot_b[B+1] ^ rot_b[B+2] ^ d3;
        end
    endgenerate

    always_comb begin
        unique case (op_i)
            OP_KEY_ONLY: pre_key = blk_i;
            OP_LAST:     pre_key = rot_flat;
            default:     pre_key = mix_flat;
        endcase
        blk_o = pre_key ^ rkey_i;
    end

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
    import aes_eng_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BLOCK_W-1:0] plain_in,
    input  logic [BLOCK_W-1:0] rkey_in,
    output logic [BLOCK_W-1:0] cipher_out,
    output logic               done
);

    ctl_state_t         cur, nxt;
    round_op_t          op;
    logic [BLOCK_W-1:0] blk_q;
    logic [BLOCK_W-1:0] round_res;
    logic               done_q;
    logic               in_round;

    aes_round_dp u_dp (
        .blk_i  (blk_q),
        .rkey_i (rkey_in),
        .op_i   (op),
        .blk_o  (round_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_RESET;
        else     cur <= nxt;
    end

    always_comb begin
        unique case (cur)
            ST_RESET: nxt = ST_WAIT;
            ST_WAIT:  nxt = load ? ST_R0 : ST_WAIT;
            ST_R0, ST_R1, ST_R2, ST_R3, ST_R4,
            ST_R5, ST_R6, ST_R7, ST_R8, ST_R9:
                      nxt = ctl_state_t'(cur + 4'd1);
            ST_R10:   nxt = ST_WAIT;
            default:  nxt = ST_RESET;
        endcase
    end

    always_comb begin
        unique case (cur)
            ST_R0:   op = OP_KEY_ONLY;
            ST_R10:  op = OP_LAST;
            default: op = OP_FULL;
        endcase
        in_round = (cur >= ST_R0) && (cur <= ST_R10);
    end

    // datapath and result flag
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            done_q <= 1'b0;
        end else if (cur == ST_WAIT && load) begin
            blk_q  <= plain_in;
            done_q <= 1'b0;
        end else if (in_round) begin
            blk_q <= round_res;
            if (cur == ST_R10) done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        done       = done_q;
        cipher_out = done_q ? blk_q : '0;
    end

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_RESET) |=> (cur == ST_WAIT));

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(cur) == ST_R10));

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_WAIT && done && !load) |=> (done && $stable(cipher_out)));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_WAIT && load) |=> (cur == ST_R0 && !done));

    // R8
    round_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur >= ST_R0 && cur < ST_R10) |=> (cur == ctl_state_t'($past(cur) + 4'd1)));

endmodule

// File: tb/sim_aes128_iter_enc.sv
`timescale 1ns/1ps
module sim_aes128_iter_enc;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [127:0] plain = '0;
    logic [127:0] rkey = '0;
    logic [127:0] cipher;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [127:0] rk [11];

    aes128_iter_enc u0 (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .plain_in   (plain),
        .rkey_in    (rkey),
        .cipher_out (cipher),
        .done       (done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bench-side field arithmetic and key schedule
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011b << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] b_sbox(input logic [7:0] x);
        logic [7:0] inv, s;
        inv = 8'h00;
        for (int y = 1; y < 256; y++) if (b_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
        return s;
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {b_sbox(t[23:16]), b_sbox(t[15:8]), b_sbox(t[7:0]), b_sbox(t[31:24])}
                  ^ {rc, 24'h0};
                rc = b_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    // run one encryption acting as the key expander
    task automatic encrypt(input logic [127:0] pt, input logic [127:0] key,
                           input bit mid_load, output logic [127:0] ct,
                           output bit lat_ok, output bit zero_ok, output bit clr_ok);
        expand(key);
        @(negedge clk);
        load  = 1'b1;
        plain = pt;
        rkey  = ~rk[0];
        @(negedge clk);                 // accepting edge passed, state R0
        load   = 1'b0;
        plain  = ~pt;
        clr_ok = (done == 1'b0) && (cipher == '0);
        lat_ok = 1'b1;
        zero_ok = 1'b1;
        for (int i = 0; i < 11; i++) begin
            rkey = rk[i];
            load = (mid_load && (i == 5 || i == 10));
            @(negedge clk);
            if (i < 10) begin
                if (done) lat_ok = 1'b0;
                if (cipher != '0) zero_ok = 1'b0;
            end
        end
        load = 1'b0;
        if (!done) lat_ok = 1'b0;
        ct = cipher;
        rkey = 128'h5a5a_a5a5_0f0f_f0f0_3c3c_c3c3_6969_9696;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", 128'(done), 128'd0);
        chk(cipher == '0, "R1 cipher in reset", cipher, 128'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(done == 1'b0 && cipher == '0, "R1 idle without load", cipher, 128'd0);
    endtask

    task automatic t_kat(input logic [127:0] pt, input logic [127:0] key,
                         input logic [127:0] exp);
        logic [127:0] ct;
        bit lat_ok, zero_ok, clr_ok;
        encrypt(pt, key, 1'b0, ct, lat_ok, zero_ok, clr_ok);
        chk(ct == exp, "R2,R3,R10 ciphertext", ct, exp);
        chk(lat_ok, "R4 done on eleventh edge", 128'(lat_ok), 128'd1);
        chk(zero_ok, "R5 zero output while busy", 128'(zero_ok), 128'd1);
        chk(clr_ok, "R7 done cleared on load", 128'(clr_ok), 128'd1);
    endtask

    task automatic t_hold();
        logic [127:0] held;
        held = cipher;
        for (int i = 0; i < 6; i++) begin
            rkey  = {4{32'hdead_beef}} ^ 128'(i * 7919);
            plain = {4{32'h1357_9bdf}} ^ 128'(i);
            @(negedge clk);
            chk(done && cipher == held, "R6,R9 result held in WAIT", cipher, held);
        end
    endtask

    task automatic t_midload(input logic [127:0] pt, input logic [127:0] key,
                             input logic [127:0] exp);
        logic [127:0] ct;
        bit lat_ok, zero_ok, clr_ok;
        encrypt(pt, key, 1'b1, ct, lat_ok, zero_ok, clr_ok);
        chk(ct == exp, "R8 load during rounds ignored", ct, exp);
        chk(lat_ok, "R8 latency unchanged", 128'(lat_ok), 128'd1);
    endtask

    task automatic t_abort(input logic [127:0] pt);
        @(negedge clk);
        load  = 1'b1;
        plain = pt;
        @(negedge clk);
        load = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (14) @(negedge clk);
        chk(done == 1'b0 && cipher == '0, "R1 aborted run does not resume", cipher, 128'd0);
    endtask

    initial begin
        t_reset();
        t_kat(128'h00112233445566778899aabbccddeeff,
              128'h000102030405060708090a0b0c0d0e0f,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        t_hold();
        t_kat(128'h3243f6a8885a308d313198a2e0370734,
              128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3925841d02dc09fbdc118597196a0b32);
        t_kat(128'h0,
              128'h0,
              128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        t_midload(128'h3243f6a8885a308d313198a2e0370734,
                  128'h2b7e151628aed2a6abf7158809cf4f3c,
                  128'h3925841d02dc09fbdc118597196a0b32);
        t_abort(128'h00112233445566778899aabbccddeeff);
        t_kat(128'h00112233445566778899aabbccddeeff,
              128'h000102030405060708090a0b0c0d0e0f,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule